// File: doc/BRIEF.md
# Receive Character Queue with Hysteretic Flow Control

This block sits behind a serial deserializer on the receive side of an asynchronous serial port. Each character arrives on a write strobe with its eight data bits and three error flags. The block queues the character, and the host pops characters in arrival order with a read strobe. A data-available interrupt rises once the queue holds at least a selectable number of characters. It drops again by itself as the host drains the queue.

The block also drives the active-low request-to-send line. When software has turned automatic flow control on, the line is released, which tells the far end to stop sending, once the fill rises well above the interrupt threshold. It is driven active again only once the fill has fallen well below that threshold. The gap between the two points keeps the line from toggling on every character. An optional interrupt flags each release of the line. With queueing switched off, the block acts as a single-character holding register.

Top module: `rx_rts_fifo`

## Requirements
- R1: Characters are returned in arrival order. Each is 8 data bits (`rdData`) plus 3 error bits (`rdErr`), and the queue holds up to 32 when `fifoEn`=1. A pop updates `rdData`/`rdErr` and `fillCount` at the clock edge that samples `rdStb`. A simultaneous write and read is allowed.
- R2: With `fifoEn`=0 the capacity is one character and the trigger is 1. Any change of `fifoEn` empties the queue at the next edge, and a write in that cycle is discarded.
- R3: `trigSel` selects the trigger: 0→1, 1→4, 2→8, 3→14, 4→16, 5→24, 6 and 7→28. `dataIrq` is 1 exactly while `fillCount` ≥ trigger.
- R4: A write that finds the queue at capacity with no pop in the same cycle is discarded, and `fillCount` is unchanged. It sets the sticky `overrun` flag, which `isrRead` clears (a new overrun in the same cycle wins).
- R5: A read of an empty queue leaves `fillCount` at 0 and keeps `rdData`/`rdErr` at their previous values.
- R6: While `rtsManual`=0, `rtsN` is 1 from the next edge on.
- R7: With `rtsManual`=1 and `autoRtsEn`=0, `rtsN` is 0 from the next edge on.
- R8: With both `rtsManual` and `autoRtsEn` at 1, `rtsN` follows a hysteresis state. It goes to 1 when `fillCount` > min(trigger+8, 31) and to 0 when `fillCount` < max(trigger−8, 1), and holds otherwise. The change appears two edges after the strobe that moved the fill across the limit.
- R9: The release-interrupt enable is written by `rtsIntEnWr` with `rtsIntEnVal` only while `rtsIntGate`=1, and a write with the gate at 0 has no effect. When enabled, a 0→1 change of `rtsN` sets `rtsEdgeIrq` at the same edge.
- R10: `isrRead` clears `rtsEdgeIrq` at the next edge unless a new release occurs in that cycle.
- R11: After reset, `fillCount`=0, `rtsN`=1, and `dataIrq`, `rtsEdgeIrq`, `overrun`, `rdData` and `rdErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Character strobe from the deserializer |
| wrData | input | 8 | Received data bits |
| wrErr | input | 3 | Received error flags (parity, framing, break) |
| rdStb | input | 1 | Host pop strobe |
| fifoEn | input | 1 | 1: 32-deep queue, 0: single holding register |
| autoRtsEn | input | 1 | Enables automatic flow control |
| rtsManual | input | 1 | Software request-to-send active |
| rtsIntGate | input | 1 | Allows writes of the release-interrupt enable |
| rtsIntEnWr | input | 1 | Write strobe for the release-interrupt enable |
| rtsIntEnVal | input | 1 | Value written to the release-interrupt enable |
| trigSel | input | 3 | Trigger level select |
| isrRead | input | 1 | Interrupt status read; clears release and overrun flags |
| rdData | output | 8 | Data bits of the last popped character |
| rdErr | output | 3 | Error bits of the last popped character |
| fillCount | output | 6 | Characters held |
| rtsN | output | 1 | Active-low request-to-send |
| dataIrq | output | 1 | Fill at or above trigger |
| rtsEdgeIrq | output | 1 | Request-to-send release flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The fill count, read data, data interrupt and overrun flag all change at the edge that samples the strobe, so the bench drives each strobe for one cycle and samples half a cycle after that edge. A change of `rtsManual` reaches `rtsN` one edge later. A fill crossing a hysteresis limit reaches `rtsN` and the release flag two edges after the strobe. The bench therefore checks that `rtsN` is still unchanged after the first edge and has flipped after one further idle cycle, and it tests both sides of each limit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rxEntryT;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCtlT;

  function automatic int trigLevel(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 14;
      3'd4:    return 16;
      3'd5:    return 24;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtlT           ctl,
  input  rxEntryT           wrEntry,
  output rxEntryT           rdEntry,
  output logic [CNT_W-1:0]  count
);
  rxEntryT store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push && !ctl.flush) store[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      rdEntry <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop) begin
        rdPtr   <= rdPtr + 1'b1;
        rdEntry <= store[rdPtr];
      end
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic             fifoEn,
  input  logic             autoRtsEn,
  input  logic             rtsManual,
  input  logic             rtsIntGate,
  input  logic             rtsIntEnWr,
  input  logic             rtsIntEnVal,
  input  logic [2:0]       trigSel,
  input  logic             isrRead,
  input  logic [CNT_W-1:0] count,
  output fifoCtlT          ctl,
  output logic             dataIrq,
  output logic             rtsN,
  output logic             rtsEdgeIrq,
  output logic             overrun
);
  logic fifoEnQ, holdOff, holdOffNext, rtsNNext, rtsIntEn, overrunSet;
  logic [CNT_W-1:0] trigLvl, upperLim, lowerLim, capacity;
  int trigInt, upInt, loInt;

  always_comb begin
    trigInt = fifoEn ? trigLevel(trigSel) : 1;
    upInt   = (trigInt + 8 > DEPTH - 1) ? DEPTH - 1 : trigInt + 8;
    loInt   = (trigInt - 8 < 1) ? 1 : trigInt - 8;
    trigLvl  = CNT_W'(trigInt);
    upperLim = CNT_W'(upInt);
    lowerLim = CNT_W'(loInt);
    capacity = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  end

  always_comb begin
    ctl.flush  = fifoEn != fifoEnQ;
    ctl.pop    = rdStb && (count != '0) && !ctl.flush;
    ctl.push   = wrStb && !ctl.flush && ((count < capacity) || ctl.pop);
    overrunSet = wrStb && !ctl.push && !ctl.flush;
  end

  assign dataIrq = count >= trigLvl;

  always_comb begin
    holdOffNext = holdOff;
    if (count > upperLim)      holdOffNext = 1'b1;
    else if (count < lowerLim) holdOffNext = 1'b0;
    rtsNNext = !rtsManual || (autoRtsEn && holdOffNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ    <= 1'b0;
      holdOff    <= 1'b0;
      rtsN       <= 1'b1;
      rtsIntEn   <= 1'b0;
      rtsEdgeIrq <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      holdOff <= holdOffNext;
      rtsN    <= rtsNNext;
      if (rtsIntEnWr && rtsIntGate) rtsIntEn <= rtsIntEnVal;
      if (rtsIntEn && rtsNNext && !rtsN) rtsEdgeIrq <= 1'b1;
      else if (isrRead)                  rtsEdgeIrq <= 1'b0;
      if (overrunSet)   overrun <= 1'b1;
      else if (isrRead) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_rts_fifo.sv
module rx_rts_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ERR_W-1:0]  wrErr,
  input  logic              rdStb,
  input  logic              fifoEn,
  input  logic              autoRtsEn,
  input  logic              rtsManual,
  input  logic              rtsIntGate,
  input  logic              rtsIntEnWr,
  input  logic              rtsIntEnVal,
  input  logic [2:0]        trigSel,
  input  logic              isrRead,
  output logic [DATA_W-1:0] rdData,
  output logic [ERR_W-1:0]  rdErr,
  output logic [CNT_W-1:0]  fillCount,
  output logic              rtsN,
  output logic              dataIrq,
  output logic              rtsEdgeIrq,
  output logic              overrun
);
  fifoCtlT ctl;
  rxEntryT wrEntry, rdEntry;

  assign wrEntry = '{err: wrErr, data: wrData};
  assign rdData  = rdEntry.data;
  assign rdErr   = rdEntry.err;

  rxq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .fifoEn(fifoEn),
    .autoRtsEn(autoRtsEn), .rtsManual(rtsManual), .rtsIntGate(rtsIntGate),
    .rtsIntEnWr(rtsIntEnWr), .rtsIntEnVal(rtsIntEnVal), .trigSel(trigSel),
    .isrRead(isrRead), .count(fillCount), .ctl(ctl), .dataIrq(dataIrq),
    .rtsN(rtsN), .rtsEdgeIrq(rtsEdgeIrq), .overrun(overrun)
  );

  rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEntry(wrEntry),
    .rdEntry(rdEntry), .count(fillCount)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrStb,
  input logic             rdStb,
  input logic             fifoEn,
  input logic             rtsManual,
  input logic [CNT_W-1:0] fillCount,
  input logic [7:0]       rdData,
  input logic             rtsN,
  input logic             rtsEdgeIrq,
  input logic             overrun
);
  // R1
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R4
  drop_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && wrStb && !rdStb && fillCount == CNT_W'(DEPTH)) |=> (overrun && fillCount == CNT_W'(DEPTH)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0 && rdStb && !wrStb) |=> (fillCount == '0 && $stable(rdData)));

  // R6
  manual_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rtsManual |=> rtsN);

  // R9
  edge_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtsEdgeIrq) |-> $rose(rtsN));
endmodule

bind rx_rts_fifo rxq_checker #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .fifoEn(fifoEn),
  .rtsManual(rtsManual), .fillCount(fillCount), .rdData(rdData),
  .rtsN(rtsN), .rtsEdgeIrq(rtsEdgeIrq), .overrun(overrun)
);

// File: tb/test_rx_rts_fifo.sv
module test_rx_rts_fifo;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrStb = 0, rdStb = 0, fifoEn = 1, autoRtsEn = 0, rtsManual = 0;
  logic rtsIntGate = 0, rtsIntEnWr = 0, rtsIntEnVal = 0, isrRead = 0;
  logic [7:0] wrData = 0;
  logic [2:0] wrErr = 0, trigSel = 3'd1;
  logic [7:0] rdData;
  logic [2:0] rdErr;
  logic [5:0] fillCount;
  logic rtsN, dataIrq, rtsEdgeIrq, overrun;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_rts_fifo i_rx_rts_fifo (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .wrErr(wrErr),
    .rdStb(rdStb), .fifoEn(fifoEn), .autoRtsEn(autoRtsEn), .rtsManual(rtsManual),
    .rtsIntGate(rtsIntGate), .rtsIntEnWr(rtsIntEnWr), .rtsIntEnVal(rtsIntEnVal),
    .trigSel(trigSel), .isrRead(isrRead), .rdData(rdData), .rdErr(rdErr),
    .fillCount(fillCount), .rtsN(rtsN), .dataIrq(dataIrq),
    .rtsEdgeIrq(rtsEdgeIrq), .overrun(overrun)
  );

  typedef struct packed {
    logic wr; logic rd; logic [7:0] d; logic [2:0] e;
    logic [5:0] cnt; logic irq; logic chk; logic [7:0] xd; logic [2:0] xe;
  } vecT;

  // trigger 4 (trigSel=1), checks R1 R3 R5
  localparam vecT VECS [12] = '{
    '{1'b1, 1'b0, 8'h11, 3'd1, 6'd1, 1'b0, 1'b0, 8'h00, 3'd0},
    '{1'b1, 1'b0, 8'h22, 3'd2, 6'd2, 1'b0, 1'b0, 8'h00, 3'd0},
    '{1'b1, 1'b0, 8'h33, 3'd0, 6'd3, 1'b0, 1'b0, 8'h00, 3'd0},
    '{1'b1, 1'b0, 8'h44, 3'd4, 6'd4, 1'b1, 1'b0, 8'h00, 3'd0},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd3, 1'b0, 1'b1, 8'h11, 3'd1},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd2, 1'b0, 1'b1, 8'h22, 3'd2},
    '{1'b1, 1'b0, 8'h55, 3'd3, 6'd3, 1'b0, 1'b0, 8'h00, 3'd0},
    '{1'b1, 1'b1, 8'h66, 3'd5, 6'd3, 1'b0, 1'b1, 8'h33, 3'd0},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd2, 1'b0, 1'b1, 8'h44, 3'd4},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd1, 1'b0, 1'b1, 8'h55, 3'd3},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd0, 1'b0, 1'b1, 8'h66, 3'd5},
    '{1'b0, 1'b1, 8'h00, 3'd0, 6'd0, 1'b0, 1'b1, 8'h66, 3'd5}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushOne(input logic [7:0] d);
    wrStb = 1; wrData = d; wrErr = d[2:0];
    tick();
    wrStb = 0;
  endtask

  task automatic popOne();
    rdStb = 1; tick(); rdStb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 count", fillCount, 0);
    chk("R11 rtsN", rtsN, 1);
    chk("R11 irqs", {dataIrq, rtsEdgeIrq, overrun}, 0);
    chk("R11 rdData", {rdErr, rdData}, 0);
    rstN = 1;
    tick(); tick();

    for (int i = 0; i < 12; i++) begin
      wrStb = VECS[i].wr; rdStb = VECS[i].rd; wrData = VECS[i].d; wrErr = VECS[i].e;
      tick();
      wrStb = 0; rdStb = 0;
      chk($sformatf("R1 count v%0d", i), fillCount, VECS[i].cnt);
      chk($sformatf("R3 dataIrq v%0d", i), dataIrq, VECS[i].irq);
      if (VECS[i].chk)
        chk($sformatf("R1 R5 data v%0d", i), {rdErr, rdData}, {VECS[i].xe, VECS[i].xd});
    end

    // R7 / R6 manual control
    rtsManual = 1; tick();
    chk("R7 rtsN active", rtsN, 0);
    rtsManual = 0; tick();
    chk("R6 rtsN released", rtsN, 1);

    // R9: enable write blocked while gate is 0
    rtsIntEnWr = 1; rtsIntEnVal = 1; rtsIntGate = 0; tick(); rtsIntEnWr = 0;
    trigSel = 3'd4; autoRtsEn = 1; rtsManual = 1; tick();
    chk("R8 rtsN on", rtsN, 0);
    for (int i = 0; i < 24; i++) pushOne(8'(i));
    tick();
    chk("R8 at upper limit", rtsN, 0);
    pushOne(8'd24);
    chk("R8 not yet", rtsN, 0);
    tick();
    chk("R8 released above 24", rtsN, 1);
    chk("R9 gated enable", rtsEdgeIrq, 0);
    for (int i = 0; i < 17; i++) popOne();
    tick();
    chk("R8 count 8", fillCount, 8);
    chk("R8 held at 8", rtsN, 1);
    popOne();
    chk("R8 not yet low", rtsN, 1);
    tick();
    chk("R8 reasserted below 8", rtsN, 0);

    // R9 enabled
    rtsIntGate = 1; rtsIntEnWr = 1; rtsIntEnVal = 1; tick(); rtsIntEnWr = 0;
    for (int i = 0; i < 18; i++) pushOne(8'(i));
    chk("R8 count 25", fillCount, 25);
    chk("R9 flag not yet", rtsEdgeIrq, 0);
    tick();
    chk("R9 rtsN rose", rtsN, 1);
    chk("R9 edge flag", rtsEdgeIrq, 1);
    isrRead = 1; tick(); isrRead = 0;
    chk("R10 flag cleared", rtsEdgeIrq, 0);

    // R4 overrun
    for (int i = 0; i < 7; i++) pushOne(8'hA0 + 8'(i));
    chk("R4 full", fillCount, 32);
    pushOne(8'hEE);
    chk("R4 dropped", fillCount, 32);
    chk("R4 overrun set", overrun, 1);
    tick();
    chk("R4 sticky", overrun, 1);
    isrRead = 1; tick(); isrRead = 0;
    chk("R4 overrun cleared", overrun, 0);

    // R3 trigger 28
    trigSel = 3'd6; tick();
    chk("R3 trig28 at 32", dataIrq, 1);
    for (int i = 0; i < 4; i++) popOne();
    chk("R3 trig28 at 28", dataIrq, 1);
    popOne();
    chk("R3 trig28 at 27", dataIrq, 0);
    trigSel = 3'd0; tick();
    chk("R3 trig1", dataIrq, 1);

    // R2 non-queue mode
    fifoEn = 0; tick();
    chk("R2 flush", fillCount, 0);
    pushOne(8'h5A);
    chk("R2 one held", fillCount, 1);
    pushOne(8'hC3);
    chk("R2 second dropped", fillCount, 1);
    chk("R2 overrun", overrun, 1);
    popOne();
    chk("R2 data", rdData, 8'h5A);
    chk("R2 count", fillCount, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule